// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column address for each beat of an SDRAM read or write burst. A memory controller pulses `startI` in the cycle of the read or write command, along with the start column, a burst-length code and a wrap-order select. From the next cycle on, the block presents one column address per clock with `colValid` high. It raises `lastBeat` on the final beat of a fixed-length burst.

A full-page burst has no natural end. It wraps around the whole column space and keeps running until `termI` stops it. The block supports two wrap orders. Sequential order counts the low address bits upward inside the burst-sized block. Interleaved order XORs the beat number into those bits. Interleaved order combined with full-page length is not a legal setting. The block reports it on `illegalCfg` and runs that burst in sequential order.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `colValid`, `lastBeat` and `illegalCfg` are all low and stay low until a start.
- R2: The start column, burst code and wrap select are captured at the clock edge where `startI` is high. Beat 0 appears in the following cycle with `colAddr` equal to the captured start column. Each later beat follows one clock after the one before it.
- R3: Burst code values 0, 1, 2 and 3 select 1, 2, 4 and 8 beats, and codes 4 to 7 select full page. After the final beat of a fixed burst, `colValid` is low in the next cycle unless a new start was sampled.
- R4: With `wrapIlv` = 0 (sequential), beat i has the upper address bits of the start column. Its low log2(BL) bits equal the start column's low bits plus i, modulo BL.
- R5: With `wrapIlv` = 1 (interleaved) and a fixed length, beat i equals the start column with its low log2(BL) bits XORed with i.
- R6: `lastBeat` is high only on beat BL-1 of a fixed-length burst, and never during a full-page burst.
- R7: A full-page burst steps through addresses modulo 256 and keeps running past 256 beats until terminated.
- R8: When `termI` is sampled high during a burst, `colValid` is low in the next cycle. If `startI` is high at the same edge, the start wins.
- R9: A start with `wrapIlv` = 1 and a full-page code holds `illegalCfg` high for every beat of that burst, and the addresses follow sequential order.
- R10: A start sampled during a running burst abandons it. The new burst's beat 0 appears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| startI | input | 1 | Start strobe, one cycle per burst |
| startCol | input | 8 | Column of the first beat |
| blCode | input | 3 | Burst length code (0..3 fixed, 4..7 full page) |
| wrapIlv | input | 1 | 0 sequential order, 1 interleaved order |
| termI | input | 1 | Terminate strobe |
| colAddr | output | 8 | Column address of the current beat |
| colValid | output | 1 | A beat is presented this cycle |
| lastBeat | output | 1 | Current beat is the last of a fixed burst |
| illegalCfg | output | 1 | Running burst asked for interleaved full page |

## Verification
The hardest situation to reach is a full-page burst that passes its 256th beat. Only there does the beat counter roll over while the last-beat logic must stay silent. The stimulus starts a full-page burst near the top of the column space and lets it run for 300 beats before terminating it, checking every address on the way. A restart that lands on the final beat of a fixed burst is also hard to reach. It needs the start strobe placed in exactly the cycle where `lastBeat` is high.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;  // capture start column, clear beat counter
    logic step;  // advance to the next beat
    logic ilv;   // interleaved address order
  } seqStrobe_t;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int BLC_W = 3,
  parameter int MAX_FIXED_CODE = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startI,
  input  logic             termI,
  input  logic [BLC_W-1:0] blCode,
  input  logic             wrapIlv,
  input  logic [COL_W-1:0] beatIdx,
  output seqStrobe_t       strb,
  output logic [COL_W-1:0] maskO,
  output logic             activeO,
  output logic             lastO,
  output logic             illegalO
);
  localparam logic [COL_W-1:0] ONE = {{(COL_W-1){1'b0}}, 1'b1};

  logic active, fullPg, ilvMode, illegal;
  logic [COL_W-1:0] mask;
  logic reqFull;
  logic [COL_W-1:0] reqMask;

  always_comb begin
    reqFull = (int'(blCode) > MAX_FIXED_CODE);
    reqMask = reqFull ? '1 : ((ONE << blCode) - ONE);
  end

  assign lastO     = active && !fullPg && (beatIdx == mask);
  assign strb.load = startI;
  assign strb.step = active && !startI && !termI && !lastO;
  assign strb.ilv  = ilvMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      fullPg  <= 1'b0;
      ilvMode <= 1'b0;
      illegal <= 1'b0;
      mask    <= '0;
    end else if (startI) begin
      active  <= 1'b1;
      fullPg  <= reqFull;
      ilvMode <= wrapIlv && !reqFull;
      illegal <= wrapIlv && reqFull;
      mask    <= reqMask;
    end else if (termI || lastO) begin
      active  <= 1'b0;
      illegal <= 1'b0;
    end
  end

  assign maskO    = mask;
  assign activeO  = active;
  assign illegalO = illegal && active;

  // R6
  fullpage_nolast_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && fullPg) |-> !lastO);
  // R8
  term_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (termI && !startI) |=> !activeO);
  // R3
  last_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lastO && !startI) |=> !activeO);
  // R9
  illegal_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegalO |-> !strb.ilv);
endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strb,
  input  logic [COL_W-1:0] startCol,
  input  logic [COL_W-1:0] mask,
  output logic [COL_W-1:0] beatIdx,
  output logic [COL_W-1:0] colAddr
);
  logic [COL_W-1:0] base, cnt;
  logic [COL_W-1:0] seqAddr, ilvAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      base <= '0;
      cnt  <= '0;
    end else if (strb.load) begin
      base <= startCol;
      cnt  <= '0;
    end else if (strb.step) begin
      cnt  <= cnt + 1'b1;
    end
  end

  always_comb begin
    seqAddr = (base & ~mask) | ((base + cnt) & mask);
    ilvAddr = base ^ (cnt & mask);
    colAddr = strb.ilv ? ilvAddr : seqAddr;
  end

  assign beatIdx = cnt;

  // R2
  step_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.load) |=> (beatIdx == $past(beatIdx) + 1'b1));
  // R2
  load_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (beatIdx == '0 && colAddr == $past(startCol)));
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 8,
  parameter int BLC_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startI,
  input  logic [COL_W-1:0] startCol,
  input  logic [BLC_W-1:0] blCode,
  input  logic             wrapIlv,
  input  logic             termI,
  output logic [COL_W-1:0] colAddr,
  output logic             colValid,
  output logic             lastBeat,
  output logic             illegalCfg
);
  seqStrobe_t strb;
  logic [COL_W-1:0] mask, beatIdx;

  burst_seq_ctrl #(.COL_W(COL_W), .BLC_W(BLC_W)) uCtrl (
    .clk(clk), .rstN(rstN), .startI(startI), .termI(termI),
    .blCode(blCode), .wrapIlv(wrapIlv), .beatIdx(beatIdx),
    .strb(strb), .maskO(mask), .activeO(colValid),
    .lastO(lastBeat), .illegalO(illegalCfg)
  );

  burst_seq_dp #(.COL_W(COL_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .startCol(startCol),
    .mask(mask), .beatIdx(beatIdx), .colAddr(colAddr)
  );

  // R6
  last_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> colValid);
  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    startI |=> colValid);
endmodule

// File: tb/tb_burst_col_seq.sv
module tb_burst_col_seq;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rstN = 0, startI = 0, wrapIlv = 0, termI = 0;
  logic [7:0] startCol = 0;
  logic [2:0] blCode = 0;
  logic [7:0] colAddr;
  logic colValid, lastBeat, illegalCfg;
  int checks = 0, errors = 0;
  bit done = 0;

  burst_col_seq dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expAddr(input logic [7:0] b, input int code,
                                         input bit ilv, input int i);
    int bl = (code > 3) ? 256 : (1 << code);
    bit useIlv = ilv && code <= 3;
    int lowB = b % bl;
    int hi = b - lowB;
    if (useIlv) return 8'(hi + (lowB ^ i));
    return 8'(hi + ((lowB + i) % bl));
  endfunction

  task automatic kick(input logic [7:0] b, input int code, input bit ilv);
    @(negedge clk);
    startI = 1; startCol = b; blCode = 3'(code); wrapIlv = ilv;
    @(negedge clk);
    startI = 0; startCol = 8'h00; blCode = 0; wrapIlv = 0;
  endtask

  // runs a fixed burst to completion, checking every beat
  task automatic fixedBurst(input string tag, input logic [7:0] b,
                            input int code, input bit ilv);
    int bl = 1 << code;
    kick(b, code, ilv);
    for (int i = 0; i < bl; i++) begin
      chk({tag, " valid"}, colValid, 1);
      chk({tag, " addr"}, colAddr, expAddr(b, code, ilv, i));
      chk({tag, " R6 last"}, lastBeat, (i == bl - 1));
      @(negedge clk);
    end
    chk({tag, " R3 end"}, colValid, 0);
  endtask

  task automatic testReset();
    chk("R1 valid", colValid, 0);
    chk("R1 last", lastBeat, 0);
    chk("R1 illegal", illegalCfg, 0);
  endtask

  task automatic testFullPage(input bit ilv);
    string tag = ilv ? "R9" : "R7";
    kick(8'hFE, 7, ilv);
    for (int i = 0; i < 300; i++) begin
      chk({tag, " valid"}, colValid, 1);
      chk({tag, " addr"}, colAddr, 8'(8'hFE + i));
      chk("R6 no last", lastBeat, 0);
      chk({tag, " illegal"}, illegalCfg, ilv);
      if (i == 299) termI = 1;
      @(negedge clk);
    end
    termI = 0;
    chk("R8 full stop", colValid, 0);
    chk("R9 illegal clr", illegalCfg, 0);
  endtask

  task automatic testTerm();
    kick(8'h40, 3, 0);
    chk("R8 beat0", colAddr, 8'h40);
    @(negedge clk);
    chk("R8 beat1", colAddr, 8'h41);
    termI = 1;
    @(negedge clk);
    termI = 0;
    chk("R8 stopped", colValid, 0);
    chk("R8 no last", lastBeat, 0);
  endtask

  task automatic testTermVsStart();
    kick(8'h10, 2, 0);
    @(negedge clk);
    startI = 1; termI = 1; startCol = 8'hA7; blCode = 1; wrapIlv = 0;
    @(negedge clk);
    startI = 0; termI = 0;
    chk("R8 start wins valid", colValid, 1);
    chk("R8 start wins addr", colAddr, 8'hA7);
    @(negedge clk);
    chk("R10 beat1", colAddr, 8'hA6);
    chk("R10 last", lastBeat, 1);
    @(negedge clk);
    chk("R10 end", colValid, 0);
  endtask

  task automatic testRestartOnLast();
    kick(8'h22, 1, 1);
    @(negedge clk);
    chk("R10 on last", lastBeat, 1);
    startI = 1; startCol = 8'h5B; blCode = 2; wrapIlv = 1;
    @(negedge clk);
    startI = 0;
    for (int i = 0; i < 4; i++) begin
      chk("R10 restart addr", colAddr, expAddr(8'h5B, 2, 1, i));
      chk("R10 restart valid", colValid, 1);
      @(negedge clk);
    end
    chk("R10 restart end", colValid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    repeat (2) @(negedge clk);
    testReset();
    fixedBurst("R4 bl4 seq", 8'h0D, 2, 0);
    fixedBurst("R5 bl8 ilv", 8'h35, 3, 1);
    fixedBurst("R3 bl1", 8'h77, 0, 1);
    fixedBurst("R4 bl2 seq", 8'h81, 1, 0);
    fixedBurst("R4 bl8 seq", 8'hFA, 3, 0);
    fixedBurst("R5 bl4 ilv", 8'hC6, 2, 1);
    testFullPage(0);
    testFullPage(1);
    testTerm();
    testTermVsStart();
    testRestartOnLast();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule